// File: doc/BRIEF.md
# Vector Extended-Dividend Word Divider

This unit divides two 128-bit vectors lane by lane. Each vector is treated as four 32-bit words. In every lane the word from operand A is moved into the upper half of a 64-bit dividend whose lower half is zero. That dividend is divided by the word from operand B, and the low 32 bits of the quotient become the lane result. This gives a fraction-style quotient, (A·2^32)/B, which is useful when a ratio below one has to be expressed in fixed point.

Two instruction variants are accepted, a signed one and an unsigned one. A small decoder looks at the 6-bit primary opcode and the 11-bit extended opcode. It admits only these two variants and chooses the arithmetic mode from them.

Work starts with a single-cycle start pulse. The unit stays busy while four identical restoring dividers each run one quotient bit per cycle. It then raises a done pulse, and the result and a per-lane divide-by-zero flag stay held until the next completion.

Top module: `vec_ext_divider`

## Requirements
- R1: A start pulse is accepted only when `prim_op` equals 6'b000100 and `ext_op` equals 11'b01110001011 (signed) or 11'b01010001011 (unsigned). Any other opcode pair leaves `busy` low and the held outputs unchanged.
- R2: When a start is accepted at a clock edge, `busy` is high from that edge for 65 cycles. At the edge where `busy` falls, `done` is high for exactly one cycle.
- R3: In unsigned mode each lane result equals the low 32 bits of ({A_lane, 32'h0} / B_lane), with both operands zero-extended.
- R4: In signed mode each lane result equals the low 32 bits of (sext64(A_lane)·2^32) / sext64(B_lane), with the quotient truncated toward zero.
- R5: Lane i occupies bits [127-32i -: 32] of `opa`, `opb` and `result`, and bit i of `zero_div`. Each lane is computed independently of the others.
- R6: A quotient that does not fit in 32 bits is neither saturated nor trapped. The lane returns the low 32 bits of the magnitude quotient, negated when the operand signs differ, with unchanged latency. For a signed A of 32'h80000000 divided by 32'hFFFFFFFF this gives 32'h00000000.
- R7: A zero divisor word gives a lane result of 32'h00000000 and sets `zero_div[i]`. The other lanes and the latency are unaffected.
- R8: A start pulse while `busy` is high is ignored. The operands latched at acceptance are kept, and the completion time does not change.
- R9: After reset, `busy`, `done`, `result` and `zero_div` are all zero.
- R10: `result` and `zero_div` change only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a division |
| prim_op | input | 6 | Primary opcode field of the instruction |
| ext_op | input | 11 | Extended opcode field of the instruction |
| opa | input | 128 | Dividend words, four lanes |
| opb | input | 128 | Divisor words, four lanes |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Lane quotients, held until the next completion |
| zero_div | output | 4 | Per-lane divide-by-zero flag, held with the result |

## Verification
The quotient register of each lane is loaded once and then shifted for 64 cycles. A wrong remainder or a wrong sign flag therefore stays hidden until `done`, and it then appears only in the affected lane's word of `result`. For that reason the reference model checks the words of every lane at every completion, and the test patterns give each lane a different value.

A wrong iteration counter shows up earlier, in the cycle-by-cycle comparison of `busy` and `done`. A restart while busy, or a rejected opcode that is wrongly accepted, is detected one cycle after the start pulse.

// File: rtl/vdx_pkg.sv
// Shared constants and types for the vector extended-dividend divider.
// Assumes the lane width is even and no wider than 64 bits.
package vdx_pkg;
    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam logic [5:0]  PRIM_VEC   = 6'b000100;
    localparam logic [10:0] EXT_SIGNED = 11'b01110001011;
    localparam logic [10:0] EXT_UNSIGN = 11'b01010001011;

    typedef enum logic { MODE_UNSIGNED = 1'b0, MODE_SIGNED = 1'b1 } div_mode_e;
endpackage

// File: rtl/vdx_decode.sv
// Opcode decoder: recognises the two extended-dividend word divide variants
// and reports which arithmetic mode to use. Purely combinational.
module vdx_decode
    import vdx_pkg::*;
(
    input  logic [5:0]  prim_op,
    input  logic [10:0] ext_op,
    output logic        valid,
    output div_mode_e   mode
);
    // Match the primary opcode and one of the two extended opcodes.
    always_comb begin
        valid = 1'b0;
        mode  = MODE_UNSIGNED;
        if (prim_op == PRIM_VEC) begin
            if (ext_op == EXT_SIGNED) begin
                valid = 1'b1;
                mode  = MODE_SIGNED;
            end else if (ext_op == EXT_UNSIGN) begin
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vdx_lane.sv
// One lane of the divider: a restoring radix-2 division on magnitudes of
// {A, zeros} / B that keeps only the low W quotient bits. It assumes the
// controller issues exactly 2*W step pulses after a load.
module vdx_lane
    import vdx_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  div_mode_e    mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo_out,
    output logic         zero_out
);
    logic [2*W-1:0] dvd_sr;
    logic [W-1:0]   dvs, rem, quo;
    logic           neg, zdiv;
    logic [W-1:0]   a_mag, b_mag;
    logic [W:0]     trial, diff;
    logic           fits;

    // Operand magnitudes at load time.
    always_comb begin
        a_mag = (mode == MODE_SIGNED && a[W-1]) ? (~a + 1'b1) : a;
        b_mag = (mode == MODE_SIGNED && b[W-1]) ? (~b + 1'b1) : b;
    end

    // One restoring trial: bring down the next dividend bit and compare.
    always_comb begin
        trial = {rem, dvd_sr[2*W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
    end

    // Load the operands, then shift one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_sr <= '0;
            dvs    <= '0;
            rem    <= '0;
            quo    <= '0;
            neg    <= 1'b0;
            zdiv   <= 1'b0;
        end else if (load) begin
            dvd_sr <= {a_mag, {W{1'b0}}};
            dvs    <= b_mag;
            rem    <= '0;
            quo    <= '0;
            neg    <= (mode == MODE_SIGNED) && (a[W-1] ^ b[W-1]);
            zdiv   <= (b == '0);
        end else if (step) begin
            dvd_sr <= dvd_sr << 1;
            rem    <= fits ? diff[W-1:0] : trial[W-1:0];
            quo    <= {quo[W-2:0], fits};
        end
    end

    // Final lane value: forced to zero on a zero divisor, else sign applied.
    always_comb begin
        zero_out = zdiv;
        if (zdiv)     quo_out = '0;
        else if (neg) quo_out = ~quo + 1'b1;
        else          quo_out = quo;
    end

    // R6: the partial remainder never reaches the divisor.
    a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs != '0) |-> (rem < dvs));
endmodule

// File: rtl/vec_ext_divider.sv
// Top level: decodes the opcode, accepts a start while idle, runs LANES
// identical lane dividers for 2*LANE_W cycles, then captures the lane
// results and raises done for one cycle. Outputs hold until next completion.
module vec_ext_divider
    import vdx_pkg::*;
#(
    parameter int W = LANE_W,
    parameter int N = LANES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [5:0]     prim_op,
    input  logic [10:0]    ext_op,
    input  logic [N*W-1:0] opa,
    input  logic [N*W-1:0] opb,
    output logic           busy,
    output logic           done,
    output logic [N*W-1:0] result,
    output logic [N-1:0]   zero_div
);
    localparam int ITER = 2 * W;
    localparam int CW   = $clog2(ITER + 1);
    localparam logic [CW-1:0] LAST = CW'(ITER);

    logic          dec_valid;
    div_mode_e     dec_mode;
    logic          accept, step, finish;
    logic [CW-1:0] cnt;
    logic [N*W-1:0] lane_q;
    logic [N-1:0]   lane_z;

    vdx_decode u_dec (
        .prim_op (prim_op),
        .ext_op  (ext_op),
        .valid   (dec_valid),
        .mode    (dec_mode)
    );

    // Handshake decisions for this cycle.
    always_comb begin
        accept = start && dec_valid && !busy;
        step   = busy && (cnt != LAST);
        finish = busy && (cnt == LAST);
    end

    // Sequencer: busy window, iteration count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (finish) begin
                busy <= 1'b0;
            end else if (step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Lane i uses the word at the top end for i = 0 (big-endian element order).
    for (genvar i = 0; i < N; i++) begin : g_lane
        vdx_lane #(.W(W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .step     (step),
            .mode     (dec_mode),
            .a        (opa[N*W-1-i*W -: W]),
            .b        (opb[N*W-1-i*W -: W]),
            .quo_out  (lane_q[N*W-1-i*W -: W]),
            .zero_out (lane_z[i])
        );
    end

    // Capture the lane results when the last iteration has been applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            zero_div <= '0;
        end else if (finish) begin
            result   <= lane_q;
            zero_div <= lane_z;
        end
    end

    // R2: done is a single-cycle pulse.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: done only follows a busy cycle and coincides with busy falling.
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    // R1: an unrecognised opcode never starts the unit.
    a_r1_reject_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !dec_valid) |=> !busy);
    // R8: busy cannot drop before the final iteration.
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);
    // R10: outputs stay put outside the completion edge.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> ($stable(result) && $stable(zero_div)));
endmodule

// File: tb/vec_ext_divider_bench.sv
module vec_ext_divider_bench;
    localparam int LAT = 65;
    localparam logic [5:0]  P_OK  = 6'b000100;
    localparam logic [10:0] E_SGN = 11'b01110001011;
    localparam logic [10:0] E_UNS = 11'b01010001011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   prim_op = '0;
    logic [10:0]  ext_op = '0;
    logic [127:0] opa = '0, opb = '0;
    logic         busy, done;
    logic [127:0] result;
    logic [3:0]   zero_div;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R9";
    bit finished = 0;

    // Reference model state
    int           m_rem = 0;
    bit           m_done = 0;
    logic [127:0] m_pend_res = '0, m_res = '0;
    logic [3:0]   m_pend_z = '0, m_z = '0;

    always #2.5 clk = ~clk;

    vec_ext_divider u_vec_ext_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .prim_op(prim_op),
        .ext_op(ext_op), .opa(opa), .opb(opb), .busy(busy), .done(done),
        .result(result), .zero_div(zero_div)
    );

    function automatic logic [31:0] ref_lane(bit sgn, logic [31:0] a, logic [31:0] b);
        longint          sq;
        longint unsigned uq;
        if (b == 0) return 32'h0;
        if (sgn) begin
            if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'h0;
            sq = (longint'($signed(a)) * 64'sd4294967296) / longint'($signed(b));
            return sq[31:0];
        end
        uq = {a, 32'h0};
        uq = uq / {32'h0, b};
        return uq[31:0];
    endfunction

    // Behavioural model of handshake and result publication.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_done = 0; m_res = '0; m_z = '0;
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
            m_done = (m_rem == 0);
            if (m_done) begin m_res = m_pend_res; m_z = m_pend_z; end
        end else begin
            m_done = 0;
            if (start && prim_op == P_OK && (ext_op == E_SGN || ext_op == E_UNS)) begin
                m_rem = LAT;
                for (int i = 0; i < 4; i++) begin
                    m_pend_res[127-32*i -: 32] = ref_lane(ext_op == E_SGN,
                        opa[127-32*i -: 32], opb[127-32*i -: 32]);
                    m_pend_z[i] = (opb[127-32*i -: 32] == 0);
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string hs;
            hs = (cur_req == "R1" || cur_req == "R8") ? cur_req : "R2";
            chk(hs, "busy", 128'(busy), 128'(m_rem > 0));
            chk(hs, "done", 128'(done), 128'(m_done));
            chk(cur_req, "result", result, m_res);
            chk(cur_req, "zero_div", 128'(zero_div), 128'(m_z));
        end
    end

    task automatic issue(logic [5:0] p, logic [10:0] e, logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        prim_op = p; ext_op = e; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(string req, logic [10:0] e, logic [127:0] a, logic [127:0] b);
        cur_req = req;
        issue(P_OK, e, a, b);
        repeat (LAT + 3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset busy", 128'(busy), 128'(0));
        chk("R9", "reset done", 128'(done), 128'(0));
        chk("R9", "reset result", result, 128'(0));
        chk("R9", "reset zero_div", 128'(zero_div), 128'(0));
        // R3: unsigned, fitting quotients, distinct per lane (R5)
        run("R3", E_UNS, {32'd1, 32'd3, 32'd100, 32'h7FFFFFFF},
                         {32'd2, 32'd7, 32'd1000, 32'hFFFFFFFF});
        run("R5", E_UNS, {32'd5, 32'd0, 32'd9, 32'd77},
                         {32'd11, 32'd13, 32'd10, 32'd1000003});
        // R4: signed, mixed signs
        run("R4", E_SGN, {32'hFFFFFFFF, 32'd1, 32'hFFFFFFF0, 32'd1234},
                         {32'd2, 32'hFFFFFFFD, 32'hFFFFFF00, 32'd99999});
        for (int k = 0; k < 6; k++) begin
            logic [127:0] a, b;
            for (int i = 0; i < 4; i++) begin
                b[127-32*i -: 32] = $urandom | 32'h1;
                a[127-32*i -: 32] = $urandom % 32'h7FFF;
            end
            run((k % 2) ? "R4" : "R3", (k % 2) ? E_SGN : E_UNS, a, b);
        end
        // R6: overflowing quotients including INT_MIN / -1
        run("R6", E_SGN, {32'h80000000, 32'h7FFFFFFF, 32'd5, 32'h80000000},
                         {32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 32'd1});
        run("R6", E_UNS, {32'd5, 32'hFFFFFFFF, 32'd2, 32'd3},
                         {32'd1, 32'd3, 32'd2, 32'd2});
        // R7: zero divisor lanes in both modes
        run("R7", E_UNS, {32'd5, 32'd6, 32'd7, 32'd8}, {32'd0, 32'd9, 32'd0, 32'd10});
        run("R7", E_SGN, {32'hFFFFFFFE, 32'd6, 32'd7, 32'd8}, {32'd0, 32'd0, 32'd0, 32'd0});
        // R1: rejected opcodes leave the unit idle
        cur_req = "R1";
        issue(P_OK, 11'b00111001011, '1, '1);
        issue(6'b000101, E_SGN, '1, '1);
        issue(P_OK, 11'b01110001010, '1, '1);
        repeat (3) @(negedge clk);
        chk("R1", "idle after bad opcode", 128'(busy), 128'(0));
        // R8: start while busy is ignored
        cur_req = "R8";
        issue(P_OK, E_UNS, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd8, 32'd8, 32'd8, 32'd8});
        repeat (10) @(negedge clk);
        issue(P_OK, E_SGN, '1, {4{32'd3}});
        repeat (LAT) @(negedge clk);
        chk("R8", "kept first operands", result,
            {32'h20000000, 32'h40000000, 32'h60000000, 32'h80000000});
        // R10: hold after a long idle
        cur_req = "R10";
        repeat (20) @(negedge clk);
        chk("R10", "held result", result,
            {32'h20000000, 32'h40000000, 32'h60000000, 32'h80000000});
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule